// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block owns the program counter of a small microcontroller core and picks the next fetch address on every clock. The candidates are: the sequential successor, a full-width jump or call target, a replacement of the low byte within the current page, a taken conditional skip, a return address supplied by an external return stack, and a fixed vector chosen by an external interrupt arbiter. Decoding, stack storage and interrupt priority all live outside. They reach this unit as single request strobes with their operands.

Any load that breaks the sequential flow sets a flush flag for the following cycle. During that cycle the instruction already fetched is discarded and the counter holds still. The unit ignores every request presented while the flag is up, because the instruction that raised it is a dummy.

Top module: `pc_next_unit`

## Requirements
- R1: A clock edge with `rst_n` low sets `pc_o` to 0x000 and `flush_o` to 0, including when a flush cycle is pending.
- R2: With no request and `flush_o` low, `pc_o` becomes `pc_o + 1` modulo 4096 at the next edge and `flush_o` stays 0. 0xFFF wraps to 0x000.
- R3: A jump or call request loads all 12 bits of `jmp_addr_i` into `pc_o`.
- R4: A low-byte write loads `pcl_data_i` into `pc_o[7:0]` and keeps `pc_o[11:8]` unchanged, so the target stays inside the current 256-word page.
- R5: A taken skip sets `pc_o` to the old value plus 2, modulo 4096.
- R6: A return request loads all 12 bits of `ret_addr_i` into `pc_o`.
- R7: An interrupt request loads the vector `4 * irq_sel_i`. The codes are: 1 comparator (0x004), 2 external line 0 (0x008), 3 multi-function (0x00C), 4 PWM (0x010), 5 timer 0 overflow (0x014), 6 timer 1 overflow (0x018). Code 0 gives the reset vector 0x000.
- R8: When several requests arrive in one cycle, the highest one wins. The order from highest to lowest is interrupt, return, jump/call, low-byte write, skip, increment.
- R9: Every load in R3 to R7 raises `flush_o` for exactly one cycle. During that cycle `pc_o` holds its value, all requests are ignored, and the next cycle resumes normal selection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req_i | input | 1 | Interrupt acknowledge, load a vector |
| irq_sel_i | input | 3 | Vector code, vector = 4 × code |
| ret_req_i | input | 1 | Return from subroutine or interrupt |
| ret_addr_i | input | 12 | Return address from the stack |
| jmp_req_i | input | 1 | Jump or call |
| jmp_addr_i | input | 12 | Jump or call target |
| pcl_wr_i | input | 1 | Write to the low byte of the counter |
| pcl_data_i | input | 8 | Value for the low byte |
| skip_i | input | 1 | Conditional skip taken |
| pc_o | output | 12 | Current fetch address |
| flush_o | output | 1 | Dummy cycle, fetched instruction is discarded |

## Verification
Every piece of state in this unit is visible at its ports one edge after it is written. A wrong counter value shows on `pc_o` in the cycle right after the faulty load. A stuck or doubled flush shows as a missing increment, or as a request that should have been ignored being honoured in the following cycle. The scoreboard therefore compares both outputs on every cycle. It drives flush-cycle requests, page boundaries and counter wrap deliberately, so that a corrupted upper page or a lost flush is caught within one or two cycles.

// File: rtl/pcu_pkg.sv
// Package: shared types of the program counter next-address unit.
// Assumes: a single source is chosen per cycle; SRC_HOLD only occurs in a
// flush (dummy) cycle.
package pcu_pkg;

    typedef enum logic [2:0] {
        SRC_INC   = 3'd0,
        SRC_SKIP  = 3'd1,
        SRC_PAGE  = 3'd2,
        SRC_JUMP  = 3'd3,
        SRC_RET   = 3'd4,
        SRC_VEC   = 3'd5,
        SRC_HOLD  = 3'd6
    } pc_src_e;

    // True for every source that breaks sequential flow.
    function automatic logic is_nonseq(input pc_src_e s);
        return (s != SRC_INC) && (s != SRC_HOLD);
    endfunction

endpackage

// File: rtl/pcu_select.sv
// Module: pcu_select
// Picks the source of the next program counter value from the request
// strobes, by fixed priority. Assumes requests are meaningless during a
// flush cycle, so all of them are masked there.
module pcu_select
    import pcu_pkg::*;
(
    input  logic    flush_q,
    input  logic    irq_req,
    input  logic    ret_req,
    input  logic    jmp_req,
    input  logic    pcl_wr,
    input  logic    skip_req,
    output pc_src_e src,
    output logic    load_nonseq
);

    // Fixed priority: interrupt, return, jump, page write, skip, increment.
    always_comb begin
        if (flush_q)       src = SRC_HOLD;
        else if (irq_req)  src = SRC_VEC;
        else if (ret_req)  src = SRC_RET;
        else if (jmp_req)  src = SRC_JUMP;
        else if (pcl_wr)   src = SRC_PAGE;
        else if (skip_req) src = SRC_SKIP;
        else               src = SRC_INC;
    end

    // A non-sequential choice schedules a dummy cycle.
    always_comb load_nonseq = is_nonseq(src);

endmodule

// File: rtl/pcu_target.sv
// Module: pcu_target
// Forms the next program counter value for the selected source.
// Assumes SEL_W + VEC_SHIFT <= ADDR_W and PAGE_W <= ADDR_W.
module pcu_target
    import pcu_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int PAGE_W    = 8,
    parameter int SEL_W     = 3,
    parameter int VEC_SHIFT = 2
) (
    input  pc_src_e           src,
    input  logic [ADDR_W-1:0] pc_q,
    input  logic [SEL_W-1:0]  vec_sel,
    input  logic [ADDR_W-1:0] ret_addr,
    input  logic [ADDR_W-1:0] jmp_addr,
    input  logic [PAGE_W-1:0] page_data,
    output logic [ADDR_W-1:0] pc_d
);

    localparam int PAD_W = ADDR_W - SEL_W - VEC_SHIFT;

    logic [ADDR_W-1:0] vec_addr;
    logic [ADDR_W-1:0] page_addr;
    logic [ADDR_W-1:0] inc1;
    logic [ADDR_W-1:0] inc2;

    // Vector address is the code scaled by the vector spacing.
    generate
        if (PAD_W > 0) begin : g_vec_pad
            assign vec_addr = {{PAD_W{1'b0}}, vec_sel, {VEC_SHIFT{1'b0}}};
        end else begin : g_vec_full
            assign vec_addr = {vec_sel, {VEC_SHIFT{1'b0}}};
        end
    endgenerate

    // Low-byte write keeps the current page bits when a page exists.
    generate
        if (PAGE_W < ADDR_W) begin : g_paged
            assign page_addr = {pc_q[ADDR_W-1:PAGE_W], page_data};
        end else begin : g_flat
            assign page_addr = page_data;
        end
    endgenerate

    // Sequential successors, wrapping at the top of program space.
    always_comb begin
        inc1 = pc_q + ADDR_W'(1);
        inc2 = pc_q + ADDR_W'(2);
    end

    // Next-value multiplexer.
    always_comb begin
        unique case (src)
            SRC_VEC:  pc_d = vec_addr;
            SRC_RET:  pc_d = ret_addr;
            SRC_JUMP: pc_d = jmp_addr;
            SRC_PAGE: pc_d = page_addr;
            SRC_SKIP: pc_d = inc2;
            SRC_INC:  pc_d = inc1;
            default:  pc_d = pc_q;
        endcase
    end

endmodule

// File: rtl/pcu_state.sv
// Module: pcu_state
// Holds the program counter and the pending-flush flag.
// Assumes a synchronous, active-low reset that wins over every load.
module pcu_state #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] pc_d,
    input  logic              flush_d,
    output logic [ADDR_W-1:0] pc_q,
    output logic              flush_q
);

    // Counter register: cleared on reset, otherwise takes the chosen value.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    // Flush flag: set for the cycle after a non-sequential load.
    always_ff @(posedge clk) begin
        if (!rst_n) flush_q <= 1'b0;
        else        flush_q <= flush_d;
    end

endmodule

// File: rtl/pc_next_unit.sv
// Module: pc_next_unit
// Top of the program counter next-address unit. It selects the next fetch
// address each cycle and flags the dummy cycle after any non-sequential load.
// Assumes: request strobes come from decode and arbitration logic outside;
// the return stack is external and presents its top entry on ret_addr_i.
module pc_next_unit
    import pcu_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int PAGE_W    = 8,
    parameter int SEL_W     = 3,
    parameter int VEC_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req_i,
    input  logic [SEL_W-1:0]  irq_sel_i,
    input  logic              ret_req_i,
    input  logic [ADDR_W-1:0] ret_addr_i,
    input  logic              jmp_req_i,
    input  logic [ADDR_W-1:0] jmp_addr_i,
    input  logic              pcl_wr_i,
    input  logic [PAGE_W-1:0] pcl_data_i,
    input  logic              skip_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic              flush_o
);

    pc_src_e           src;
    logic              load_nonseq;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_d;
    logic              flush_q;

    pcu_select u_select (
        .flush_q     (flush_q),
        .irq_req     (irq_req_i),
        .ret_req     (ret_req_i),
        .jmp_req     (jmp_req_i),
        .pcl_wr      (pcl_wr_i),
        .skip_req    (skip_i),
        .src         (src),
        .load_nonseq (load_nonseq)
    );

    pcu_target #(
        .ADDR_W    (ADDR_W),
        .PAGE_W    (PAGE_W),
        .SEL_W     (SEL_W),
        .VEC_SHIFT (VEC_SHIFT)
    ) u_target (
        .src       (src),
        .pc_q      (pc_q),
        .vec_sel   (irq_sel_i),
        .ret_addr  (ret_addr_i),
        .jmp_addr  (jmp_addr_i),
        .page_data (pcl_data_i),
        .pc_d      (pc_d)
    );

    pcu_state #(
        .ADDR_W (ADDR_W)
    ) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .pc_d    (pc_d),
        .flush_d (load_nonseq),
        .pc_q    (pc_q),
        .flush_q (flush_q)
    );

    // Outputs come straight from the state registers.
    assign pc_o    = pc_q;
    assign flush_o = flush_q;

endmodule

// File: rtl/pcu_checker.sv
// Module: pcu_checker
// Temporal checks on the ports of pc_next_unit, attached by bind.
// Assumes the top's parameters are passed through unchanged.
module pcu_checker #(
    parameter int ADDR_W    = 12,
    parameter int PAGE_W    = 8,
    parameter int SEL_W     = 3,
    parameter int VEC_SHIFT = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_req_i,
    input logic [SEL_W-1:0]  irq_sel_i,
    input logic              ret_req_i,
    input logic [ADDR_W-1:0] ret_addr_i,
    input logic              jmp_req_i,
    input logic [ADDR_W-1:0] jmp_addr_i,
    input logic              pcl_wr_i,
    input logic [PAGE_W-1:0] pcl_data_i,
    input logic              skip_i,
    input logic [ADDR_W-1:0] pc_o,
    input logic              flush_o
);

    localparam int STRIDE = 1 << VEC_SHIFT;

    logic              idle_now;
    logic [ADDR_W-1:0] vec_expect;
    logic              seen_edge;

    // Helper terms: no request, and the expected vector for the current code.
    always_comb begin
        idle_now   = !(irq_req_i || ret_req_i || jmp_req_i || pcl_wr_i || skip_i);
        vec_expect = ADDR_W'(irq_sel_i) * ADDR_W'(STRIDE);
    end

    // Marks that at least one edge has passed, so $past is meaningful.
    always_ff @(posedge clk) seen_edge <= 1'b1;

    // Reset check as an immediate assertion.
    always @(posedge clk) begin
        if (seen_edge === 1'b1 && $past(rst_n) === 1'b0) begin
            AST_RESET_CLEARS: assert (pc_o == '0 && !flush_o); // R1
        end
    end

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_o && idle_now) |=> (pc_o == $past(pc_o) + ADDR_W'(1) && !flush_o)); // R2
    AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_o && jmp_req_i && !irq_req_i && !ret_req_i) |=> (pc_o == $past(jmp_addr_i))); // R3
    AST_PAGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_o && pcl_wr_i && !irq_req_i && !ret_req_i && !jmp_req_i)
        |=> (pc_o[ADDR_W-1:PAGE_W] == $past(pc_o[ADDR_W-1:PAGE_W])
             && pc_o[PAGE_W-1:0] == $past(pcl_data_i))); // R4
    AST_SKIP_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_o && skip_i && !irq_req_i && !ret_req_i && !jmp_req_i && !pcl_wr_i)
        |=> (pc_o == $past(pc_o) + ADDR_W'(2))); // R5
    AST_RET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_o && ret_req_i && !irq_req_i) |=> (pc_o == $past(ret_addr_i))); // R6
    AST_VEC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_o && irq_req_i) |=> (pc_o == $past(vec_expect))); // R7
    AST_LOAD_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_o && !idle_now) |=> flush_o); // R9
    AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> !flush_o); // R9
    AST_FLUSH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> $stable(pc_o)); // R9

endmodule

bind pc_next_unit pcu_checker #(
    .ADDR_W    (ADDR_W),
    .PAGE_W    (PAGE_W),
    .SEL_W     (SEL_W),
    .VEC_SHIFT (VEC_SHIFT)
) u_pcu_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_req_i  (irq_req_i),
    .irq_sel_i  (irq_sel_i),
    .ret_req_i  (ret_req_i),
    .ret_addr_i (ret_addr_i),
    .jmp_req_i  (jmp_req_i),
    .jmp_addr_i (jmp_addr_i),
    .pcl_wr_i   (pcl_wr_i),
    .pcl_data_i (pcl_data_i),
    .skip_i     (skip_i),
    .pc_o       (pc_o),
    .flush_o    (flush_o)
);

// File: tb/tb_pc_next_unit.sv
// Scoreboard bench for pc_next_unit. The driver applies one cycle of stimulus
// at each falling edge and queues the outputs the requirements predict. The
// monitor compares them 1 ns after the following rising edge.
module tb_pc_next_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        irq_req_i;
    logic [2:0]  irq_sel_i;
    logic        ret_req_i;
    logic [11:0] ret_addr_i;
    logic        jmp_req_i;
    logic [11:0] jmp_addr_i;
    logic        pcl_wr_i;
    logic [7:0]  pcl_data_i;
    logic        skip_i;
    logic [11:0] pc_o;
    logic        flush_o;

    typedef struct {
        logic [11:0] pc;
        logic        fl;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    logic [11:0] m_pc = '0;
    logic        m_fl = 1'b0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    pc_next_unit dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_req_i  (irq_req_i),
        .irq_sel_i  (irq_sel_i),
        .ret_req_i  (ret_req_i),
        .ret_addr_i (ret_addr_i),
        .jmp_req_i  (jmp_req_i),
        .jmp_addr_i (jmp_addr_i),
        .pcl_wr_i   (pcl_wr_i),
        .pcl_data_i (pcl_data_i),
        .skip_i     (skip_i),
        .pc_o       (pc_o),
        .flush_o    (flush_o)
    );

    // Driver: one cycle of stimulus plus the predicted result.
    task automatic step(input bit rn, input bit irq, input logic [2:0] sel,
                        input bit ret, input logic [11:0] ra,
                        input bit jmp, input logic [11:0] ja,
                        input bit lw, input logic [7:0] ld,
                        input bit sk, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = rn; irq_req_i = irq; irq_sel_i = sel; ret_req_i = ret;
        ret_addr_i = ra; jmp_req_i = jmp; jmp_addr_i = ja;
        pcl_wr_i = lw; pcl_data_i = ld; skip_i = sk;
        if (!rn) begin m_pc = 12'h000; m_fl = 1'b0; end
        else if (m_fl) begin m_fl = 1'b0; end
        else if (irq) begin m_pc = 12'(sel) * 12'd4; m_fl = 1'b1; end
        else if (ret) begin m_pc = ra; m_fl = 1'b1; end
        else if (jmp) begin m_pc = ja; m_fl = 1'b1; end
        else if (lw)  begin m_pc = {m_pc[11:8], ld}; m_fl = 1'b1; end
        else if (sk)  begin m_pc = m_pc + 12'd2; m_fl = 1'b1; end
        else          begin m_pc = m_pc + 12'd1; m_fl = 1'b0; end
        e.pc = m_pc; e.fl = m_fl; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(1, 0, 3'd0, 0, 12'h0, 0, 12'h0, 0, 8'h0, 0, tag);
    endtask

    // Monitor: compare every queued prediction after the rising edge.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                n_cmp++;
                if (pc_o !== e.pc || flush_o !== e.fl) begin
                    n_bad++;
                    $display("FAIL %s: pc=%03h flush=%0b expected pc=%03h flush=%0b",
                             e.tag, pc_o, flush_o, e.pc, e.fl);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        step(0, 0, 3'd0, 0, 12'h0, 0, 12'h0, 0, 8'h0, 0, "R1 reset");
        step(0, 1, 3'd5, 0, 12'h0, 1, 12'h777, 0, 8'h0, 0, "R1 reset beats requests");
        for (int i = 0; i < 4; i++) idle("R2 increment");
        step(1, 0, 3'd0, 0, 12'h0, 1, 12'hFFE, 0, 8'h0, 0, "R3 jump full width");
        idle("R9 flush hold after jump");
        idle("R2 increment to top");
        idle("R2 wrap to zero");
        step(1, 0, 3'd0, 0, 12'h0, 1, 12'h5A3, 0, 8'h0, 0, "R3 call target");
        idle("R9 flush");
        step(1, 0, 3'd0, 0, 12'h0, 0, 12'h0, 1, 8'h10, 0, "R4 page write keeps upper bits");
        idle("R9 flush after page write");
        step(1, 0, 3'd0, 0, 12'h0, 0, 12'h0, 1, 8'hFF, 0, "R4 page write top of page");
        idle("R9 flush");
        idle("R2 increment crosses page");
        step(1, 0, 3'd0, 0, 12'h0, 0, 12'h0, 0, 8'h0, 1, "R5 skip adds two");
        idle("R9 flush after skip");
        step(1, 0, 3'd0, 0, 12'h0, 1, 12'hFFF, 0, 8'h0, 0, "R3 jump to top");
        idle("R9 flush");
        step(1, 0, 3'd0, 0, 12'h0, 0, 12'h0, 0, 8'h0, 1, "R5 skip wraps");
        idle("R9 flush");
        step(1, 0, 3'd0, 1, 12'hABC, 0, 12'h0, 0, 8'h0, 0, "R6 return");
        idle("R9 flush after return");
        for (int s = 0; s < 8; s++) begin
            step(1, 1, 3'(s), 0, 12'h0, 0, 12'h0, 0, 8'h0, 0, "R7 vector");
            idle("R9 flush after vector");
        end
        step(1, 1, 3'd3, 1, 12'h111, 1, 12'h222, 1, 8'h33, 1, "R8 interrupt wins");
        idle("R9 flush");
        step(1, 0, 3'd0, 1, 12'h444, 1, 12'h555, 1, 8'h66, 1, "R8 return over jump");
        idle("R9 flush");
        step(1, 0, 3'd0, 0, 12'h0, 1, 12'h777, 1, 8'h88, 1, "R8 jump over page write");
        idle("R9 flush");
        step(1, 0, 3'd0, 0, 12'h0, 0, 12'h0, 1, 8'h99, 1, "R8 page write over skip");
        step(1, 1, 3'd6, 1, 12'h123, 1, 12'h321, 1, 8'h45, 1, "R9 requests ignored in flush");
        idle("R9 resume increment");
        step(1, 0, 3'd0, 0, 12'h0, 1, 12'h800, 0, 8'h0, 0, "R3 jump");
        step(0, 0, 3'd0, 0, 12'h0, 0, 12'h0, 0, 8'h0, 0, "R1 reset clears pending flush");
        idle("R2 increment after reset");
        idle("R2 increment");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule